// File: doc/BRIEF.md
# Spread-Spectrum Profile Generator

This block is the digital sweep controller of a spread-spectrum clock synthesizer. It runs on the reference clock. Once per reference cycle it produces a signed fractional offset word, and a downstream fractional feedback divider adds that word to pull the synthesized frequency away from nominal. The offset traces a periodic triangle. The triangle's period is a fixed multiple of the reference period, chosen by a rate pin and a build parameter. Its amplitude comes from a spread percentage decoded from two range pins and a down/center pin.

One offset LSB is 1/65536 of nominal frequency, so a spread of `x` percent maps to a magnitude of round(x × 655.36). The select pins are static straps, and the block samples them only when a modulation period begins, so a strap change never breaks a sweep in progress. Pulling the active-low power-down input low clears the sweep and forces a zero offset. On release the sweep restarts at its zero-offset phase. The block also passes the reference clock through unchanged as an unmodulated reference output.

Top module: `spread_profile_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after `sleep_n` is sampled low, `offset` is 0. It stays 0 for as long as `sleep_n` is held low.
- R2: With `LONG_RATE` = 0, the modulation period is 256 reference cycles when `rate_sel` = 0 and 512 when `rate_sel` = 1. `offset` is exactly 0 at the end of every period.
- R3: With `LONG_RATE` = 1, the modulation period is 2048 reference cycles when `rate_sel` = 0 and 3584 when `rate_sel` = 1.
- R4: In down mode (`center_sel` = 0), the range code {`span_hi`,`span_lo`} selects a peak magnitude `P` = round(pct × 655.36). The codes are 00 → 1.25 % (819), 01 → 2.5 % (1638), 10 → 1.75 % (1147) and 11 → 3.5 % (2294).
- R5: In center mode (`center_sel` = 1), the same code selects half the down percentage. The amplitude `A` is 410, 819, 573 or 1147 for codes 00, 01, 10 and 11.
- R6: In down mode with half period H = period/2, `offset` after k steps of a period is −min(k·s, P) for k ≤ H and min(−P + (k−H)·s, 0) for k > H. It is never positive.
- R7: In center mode with Q = H/2, `offset` rises as min(k·s, A) for k ≤ Q. It then falls as max(A − (k−Q)·s, −A) for k ≤ 3Q, and finally rises as min(−A + (k−3Q)·s, 0).
- R8: The step `s` is ceil(span/H), where span is P in down mode and 2A in center mode. Each step saturates at the bound of its segment, so every peak and trough is reached exactly.
- R9: The select pins are sampled only on the clock edge that starts a period. A pin change inside a period takes effect at the start of the next period.
- R10: After `sleep_n` returns high, the sweep restarts at k = 1 of a new period, using the pins present at that edge.
- R11: `ref_clk` follows `clk` at all times, including during power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low power-down; low forces zero offset |
| rate_sel | input | 1 | Modulation period select (short/long divisor) |
| span_hi | input | 1 | Spread range code, upper bit |
| span_lo | input | 1 | Spread range code, lower bit |
| center_sel | input | 1 | 0 = down spread, 1 = center spread |
| offset | output | OW | Signed frequency offset, 1/65536 of nominal per LSB |
| ref_clk | output | 1 | Unmodulated reference clock |

## Verification
A corrupted phase counter or accumulator appears at `offset` on the very next cycle. It shows as a value off the closed-form triangle, a nonzero word at a period boundary, or, with a wrong period length, a zero that lands at the wrong cycle. A wrong step or table entry shows up within the first few cycles of a half period as a slope mismatch, or at the peak as a wrong plateau value. A configuration that is latched at the wrong time shows up as a shape change in the middle of a period, at the cycle after the pin toggles rather than at the next boundary.

// File: rtl/spread_profile_gen.sv
module spread_profile_gen #(
  parameter bit LONG_RATE = 1'b0,
  parameter int OW        = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_n,
  input  logic                 rate_sel,
  input  logic                 span_hi,
  input  logic                 span_lo,
  input  logic                 center_sel,
  output logic signed [OW-1:0] offset,
  output logic                 ref_clk
);
  localparam int DIV_A = LONG_RATE ? 2048 : 256;
  localparam int DIV_B = LONG_RATE ? 3584 : 512;
  localparam int PW    = $clog2(DIV_B);
  localparam logic [PW-1:0] LAST_A = PW'(DIV_A - 1);
  localparam logic [PW-1:0] LAST_B = PW'(DIV_B - 1);

  function automatic int peak_of(int idx, bit ctr);
    case (idx)
      0:       return ctr ? 410  : 819;
      1:       return ctr ? 819  : 1638;
      2:       return ctr ? 573  : 1147;
      default: return ctr ? 1147 : 2294;
    endcase
  endfunction

  // sel = {rate, center, range[1:0]}
  function automatic int step_of(int sel);
    int ctr, span, half;
    ctr  = (sel / 4) % 2;
    span = (ctr == 1) ? 2 * peak_of(sel % 4, 1'b1) : peak_of(sel % 4, 1'b0);
    half = ((sel / 8) % 2 == 1) ? DIV_B / 2 : DIV_A / 2;
    return (span + half - 1) / half;
  endfunction

  localparam int MAX_STEP = step_of(3);

  logic [PW-1:0]        phase;
  logic [3:0]           cfg_q;
  logic signed [OW-1:0] acc, acc_nxt;
  logic [OW-1:0]        step_tab [16];
  logic [OW-1:0]        peak_tab [8];

  for (genvar g = 0; g < 16; g++) begin : g_step
    assign step_tab[g] = OW'(step_of(g));
  end
  for (genvar g = 0; g < 8; g++) begin : g_peak
    assign peak_tab[g] = OW'(peak_of(g % 4, g >= 4));
  end

  wire [3:0] cur  = (phase == '0) ? {rate_sel, center_sel, span_hi, span_lo} : cfg_q;
  wire       wrap = cur[3] ? (phase == LAST_B) : (phase == LAST_A);

  always_comb begin
    int a, s, p, h, ph, n;
    a  = int'(acc);
    s  = int'(step_tab[cur]);
    p  = int'(peak_tab[cur[2:0]]);
    h  = cur[3] ? DIV_B / 2 : DIV_A / 2;
    ph = int'(phase);
    if (!cur[2])
      n = (ph < h) ? ((a - s < -p) ? -p : a - s) : ((a + s > 0) ? 0 : a + s);
    else if (ph < h / 2)
      n = (a + s > p) ? p : a + s;
    else if (ph < 3 * h / 2)
      n = (a - s < -p) ? -p : a - s;
    else
      n = (a + s > 0) ? 0 : a + s;
    acc_nxt = OW'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      acc   <= '0;
      cfg_q <= '0;
    end else if (!sleep_n) begin
      phase <= '0;
      acc   <= '0;
    end else begin
      cfg_q <= cur;
      acc   <= acc_nxt;
      phase <= wrap ? '0 : phase + 1'b1;
    end
  end

  assign offset  = acc;
  assign ref_clk = clk;

  p_pd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> offset == '0);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && phase == '0) |-> offset == '0);

  p_down_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[2] |-> (int'(offset) <= 0 && int'(offset) >= -int'(peak_tab[cfg_q[2:0]])));

  p_center_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2] |-> (int'(offset) <= int'(peak_tab[cfg_q[2:0]]) &&
                  int'(offset) >= -int'(peak_tab[cfg_q[2:0]])));

  p_slew_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && $past(sleep_n)) |->
      (int'(offset) - int'($past(offset)) <= MAX_STEP &&
       int'($past(offset)) - int'(offset) <= MAX_STEP));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && phase != '0) |=> $stable(cfg_q));
endmodule

// File: tb/spread_profile_gen_tb_top.sv
`timescale 1ns/1ps
module spread_profile_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b0;
  logic rate_sel = 1'b0, span_hi = 1'b0, span_lo = 1'b0, center_sel = 1'b0;
  logic signed [15:0] off_s, off_l;
  logic ref_s, ref_l;
  int tests = 0, fails = 0;
  int ph [2];
  logic [3:0] cm [2];

  always #5 clk = ~clk;

  spread_profile_gen #(.LONG_RATE(1'b0), .OW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .rate_sel(rate_sel),
    .span_hi(span_hi), .span_lo(span_lo), .center_sel(center_sel),
    .offset(off_s), .ref_clk(ref_s));

  spread_profile_gen #(.LONG_RATE(1'b1), .OW(16)) long_i (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .rate_sel(rate_sel),
    .span_hi(span_hi), .span_lo(span_lo), .center_sel(center_sel),
    .offset(off_l), .ref_clk(ref_l));

  function automatic int pk(int idx, bit ctr);
    real pct;
    case (idx)
      0: pct = 1.25;
      1: pct = 2.5;
      2: pct = 1.75;
      default: pct = 3.5;
    endcase
    if (ctr) pct = pct / 2.0;
    return $rtoi(pct * 655.36 + 0.5);
  endfunction

  function automatic int divof(int inst, logic r);
    if (inst == 1) return r ? 3584 : 2048;
    return r ? 512 : 256;
  endfunction

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  // c = {rate, center, range}; k = steps into the period (1..D)
  function automatic int expv(int inst, logic [3:0] c, int k);
    int d, h, q, p, span, s;
    d    = divof(inst, c[3]);
    h    = d / 2;
    q    = h / 2;
    p    = pk(int'(c[1:0]), c[2]);
    span = c[2] ? 2 * p : p;
    s    = (span + h - 1) / h;
    if (!c[2]) return (k <= h) ? -mn(k * s, p) : mn(-p + (k - h) * s, 0);
    if (k <= q)     return mn(k * s, p);
    if (k <= 3 * q) return mx(p - (k - q) * s, -p);
    return mn(-p + (k - 3 * q) * s, 0);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic release_pd();
    @(negedge clk);
    sleep_n = 1'b1;
    ph[0] = 0;
    ph[1] = 0;
  endtask

  task automatic run(string req, int cycles, int chg_at, logic [3:0] np);
    for (int n = 1; n <= cycles; n++) begin
      int e [2];
      logic [3:0] pins;
      pins = {rate_sel, center_sel, span_hi, span_lo};
      for (int i = 0; i < 2; i++) begin
        if (ph[i] == 0) cm[i] = pins;
        e[i]  = expv(i, cm[i], ph[i] + 1);
        ph[i] = (ph[i] + 1) % divof(i, cm[i][3]);
      end
      @(negedge clk);
      check(req, int'(off_s), e[0]);
      check(req, int'(off_l), e[1]);
      if (n == chg_at) {rate_sel, center_sel, span_hi, span_lo} = np;
    end
  endtask

  task automatic power_down(string req, int hold);
    @(negedge clk);
    sleep_n = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(req, int'(off_s), 0);
      check(req, int'(off_l), 0);
    end
  endtask

  initial begin
    #1;
    check("R1 reset", int'(off_s), 0);
    check("R1 reset", int'(off_l), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held in power-down", int'(off_s), 0);

    // exhaustive sweep over every strap combination: R2 R3 R4 R5 R6 R7 R8
    for (int c = 0; c < 16; c++) begin
      {rate_sel, center_sel, span_hi, span_lo} = 4'(c);
      @(negedge clk);
      release_pd();
      run(c[2] ? "R5 R7 R8 center sweep" : "R4 R6 R8 down sweep",
          c[3] ? 3584 : 2048, 0, 4'b0000);
      power_down("R1 power-down", 2);
    end

    // R9: mid-period strap change takes effect only at next period
    {rate_sel, center_sel, span_hi, span_lo} = 4'b0011;
    release_pd();
    run("R9 strap sampling", 600, 100, 4'b0101);
    run("R9 strap sampling", 300, 40, 4'b1110);

    // R10: power-down mid-sweep, then restart from zero phase
    power_down("R1 mid-sweep power-down", 3);
    {rate_sel, center_sel, span_hi, span_lo} = 4'b0110;
    release_pd();
    run("R10 restart after power-down", 400, 0, 4'b0000);

    // R11: reference clock passes through, also while powered down
    power_down("R1 power-down", 1);
    @(posedge clk);
    #2;
    check("R11 ref high", int'(ref_s), 1);
    check("R11 ref high", int'(ref_l), 1);
    @(negedge clk);
    #1;
    check("R11 ref low", int'(ref_s), 0);
    check("R11 ref low", int'(ref_l), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule